// File: doc/BRIEF.md
# Multiprocessor Device Interrupt Controller

This block routes device interrupts and inter-processor interrupts to up to four CPUs, and it latches a periodic timer interrupt for each CPU. It samples 64 level-sensitive device request lines into a shared request register. Each CPU owns a 64-bit enable mask, and the block keeps a per-CPU pending register that always equals that CPU's mask ANDed with the shared request register. For each CPU the block drives a device interrupt output, which is high while that CPU has a pending bit, and a timer interrupt output.

Software reaches the block through a single 64-bit register port. A request carries a byte offset, a write flag, a size code, write data and the ID of the requesting CPU. Every request is answered one cycle later with an acknowledge, an error flag and read data. Acknowledges for inter-processor and timer interrupts are gathered in one shared miscellaneous register, split into per-CPU bit fields. Dedicated registers also exist to set or clear these bits directly.

Top module: `dev_irq_ctrl`

## Requirements
- R1: The register index is the byte offset shifted right by 6. Offset bits 5:3 are ignored. The map is: 0 control, 1 misc, 2..5 address slots, 6..9 mask of CPU 0..3, 10..13 pending of CPU 0..3, 14 request, 15 IPI status/clear, 16 timer status/clear, 17 IPI set.
- R2: An access whose size code is not 3 (codes 0/1/2/3 mean 8/16/32/64 bits), or whose offset bits 2:0 are nonzero, returns the error flag and changes no register.
- R3: The pending register of every CPU equals its mask AND the request register. It is updated on the same clock edge as a mask write or a request change.
- R4: The device interrupt output of CPU n is high exactly when pending[n] is nonzero. A mask write that masks the last pending bit drops the output on that same edge.
- R5: The request bit k takes the level of device line k one clock edge after the line changes. A line that stays low leaves its bit at zero, so a repeated clear has no effect.
- R6: In a misc write, data bits 15:12 set the IPI bit of CPUs 3..0, bits 11:8 clear it, and bits 7:4 clear the timer bit. When the same write both sets and clears an IPI bit, the set wins.
- R7: A misc write that has none of bits 15:4 set is still accepted when bit 28 is set. If bit 28 is also clear, the write is flagged as an error.
- R8: A timer tick sets every CPU's timer bit on the next edge, and the timer outputs follow those bits. A tick in the same cycle as a timer clear wins over the clear.
- R9: Writing register 15 clears the IPI bits that are set in data bits 3:0. Writing register 16 clears the timer bits given in data bits 3:0. Writing register 17 sets the IPI bits given in data bits 3:0.
- R10: The control register and the address slots read as zero. A misc read returns the IPI bits in 11:8, the timer bits in 7:4 and the requester's CPU ID in 1:0.
- R11: Reads of the mask, pending, request, IPI (15) and timer (16) registers return their current values.
- R12: Every request is acknowledged for exactly one cycle, on the cycle after it. An unimplemented index, a write to a read-only register (0, 2..5, 10..14) or a read of register 17 raises the error flag with that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq_i | input | 64 | Device interrupt request levels |
| tick_i | input | 1 | Periodic timer tick pulse |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset from block base |
| req_size_i | input | 2 | Access size code, 3 = 64 bit |
| req_wdata_i | input | 64 | Write data |
| req_cpu_i | input | 2 | ID of requesting CPU |
| ack_o | output | 1 | Access acknowledge, one cycle after request |
| err_o | output | 1 | Error response, valid with ack_o |
| rdata_o | output | 64 | Read data, valid with ack_o |
| dev_int_o | output | 4 | Per-CPU device interrupt level |
| tmr_int_o | output | 4 | Per-CPU timer interrupt level |

## Verification
The masking function is exercised in three ways. Random device line patterns are crossed with random per-CPU masks, which shows whether each CPU's pending value and output track its own mask and not a neighbour's. Full-mask, empty-mask and single-bit patterns show the edge of the last pending bit being masked away. Misc writes are driven with single fields, combined set-and-clear fields, the accept bit alone and all-zero data, so that the per-field decoding and the error rule can be told apart. Directed ticks land on CPUs that are already pending and collide with timer clears. Undersized, misaligned and wrong-direction accesses are followed by readback, to show that no state changed.

// File: rtl/dic_pkg.sv
package dic_pkg;
    localparam int IDX_CTRL  = 0;
    localparam int IDX_MISC  = 1;
    localparam int IDX_AAR0  = 2;
    localparam int N_AAR     = 4;
    localparam int IDX_MASK0 = IDX_AAR0 + N_AAR;

    localparam logic [1:0] SZ_64 = 2'd3;

    localparam int F_TMR_CLR  = 4;
    localparam int F_IPI_CLR  = 8;
    localparam int F_IPI_SET  = 12;
    localparam int MISC_ACCEPT = 28;

    typedef enum logic [3:0] {
        K_ZERO, K_MISC, K_MASK, K_PEND, K_REQ,
        K_IPI_CLR, K_TMR_CLR, K_IPI_SET, K_BAD
    } acc_kind_e;
endpackage

// File: rtl/dic_decode.sv
module dic_decode
    import dic_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NCPU   = 4,
    parameter int CPU_W  = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              write_i,
    input  logic [1:0]        size_i,
    output acc_kind_e         kind_o,
    output logic [CPU_W-1:0]  cpu_sel_o,
    output logic              bad_o
);
    localparam int IDX_PEND0   = IDX_MASK0 + NCPU;
    localparam int IDX_REQ     = IDX_PEND0 + NCPU;
    localparam int IDX_IPI_CLR = IDX_REQ + 1;
    localparam int IDX_TMR_CLR = IDX_REQ + 2;
    localparam int IDX_IPI_SET = IDX_REQ + 3;

    int idx;
    logic ro_hit;

    always_comb begin
        idx       = int'(addr_i[ADDR_W-1:6]);
        kind_o    = K_BAD;
        cpu_sel_o = '0;
        if (idx == IDX_CTRL || (idx >= IDX_AAR0 && idx < IDX_AAR0 + N_AAR)) begin
            kind_o = K_ZERO;
        end else if (idx == IDX_MISC) begin
            kind_o = K_MISC;
        end else if (idx >= IDX_MASK0 && idx < IDX_MASK0 + NCPU) begin
            kind_o    = K_MASK;
            cpu_sel_o = CPU_W'(idx - IDX_MASK0);
        end else if (idx >= IDX_PEND0 && idx < IDX_PEND0 + NCPU) begin
            kind_o    = K_PEND;
            cpu_sel_o = CPU_W'(idx - IDX_PEND0);
        end else if (idx == IDX_REQ) begin
            kind_o = K_REQ;
        end else if (idx == IDX_IPI_CLR) begin
            kind_o = K_IPI_CLR;
        end else if (idx == IDX_TMR_CLR) begin
            kind_o = K_TMR_CLR;
        end else if (idx == IDX_IPI_SET) begin
            kind_o = K_IPI_SET;
        end
        ro_hit = write_i && (kind_o == K_ZERO || kind_o == K_PEND || kind_o == K_REQ);
        bad_o  = (size_i != SZ_64) || (addr_i[2:0] != 3'd0) || (kind_o == K_BAD)
               || ro_hit || (!write_i && kind_o == K_IPI_SET);
    end
endmodule

// File: rtl/dic_cpu_slice.sv
module dic_cpu_slice #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we_i,
    input  logic [DATA_W-1:0] mask_wdata_i,
    input  logic [DATA_W-1:0] req_d_i,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] pend_o,
    output logic              dev_int_o
);
    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] pend;
    } slice_t;

    slice_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (mask_we_i) begin
            s_d.mask = mask_wdata_i;
        end
        s_d.pend = s_d.mask & req_d_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mask_o    = s_q.mask;
    assign pend_o    = s_q.pend;
    assign dev_int_o = |s_q.pend;

    // R4: masking everything must drop the output on the next edge
    p_mask_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we_i && mask_wdata_i == '0) |=> !dev_int_o);
endmodule

// File: rtl/dev_irq_ctrl.sv
module dev_irq_ctrl
    import dic_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int NCPU   = 4,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] dev_irq_i,
    input  logic              tick_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_size_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [1:0]        req_cpu_i,
    output logic              ack_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [NCPU-1:0]   dev_int_o,
    output logic [NCPU-1:0]   tmr_int_o
);
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1;

    typedef struct packed {
        logic              ack;
        logic              err;
        logic [DATA_W-1:0] rdata;
        logic [DATA_W-1:0] req;
        logic [NCPU-1:0]   ipi;
        logic [NCPU-1:0]   tmr;
    } ctl_t;

    ctl_t s_d, s_q;

    acc_kind_e             kind;
    logic [CPU_W-1:0]      cpu_sel;
    logic                  bad;
    logic [NCPU-1:0]       mask_we;
    logic [NCPU-1:0][DATA_W-1:0] mask_arr;
    logic [NCPU-1:0][DATA_W-1:0] pend_arr;
    logic [NCPU-1:0]       ipi_set, ipi_clr, tmr_clr;
    logic                  misc_empty;

    dic_decode #(.ADDR_W(ADDR_W), .NCPU(NCPU), .CPU_W(CPU_W)) i_decode (
        .addr_i   (req_addr_i),
        .write_i  (req_write_i),
        .size_i   (req_size_i),
        .kind_o   (kind),
        .cpu_sel_o(cpu_sel),
        .bad_o    (bad)
    );

    always_comb begin
        s_d       = s_q;
        s_d.ack   = req_valid_i;
        s_d.err   = 1'b0;
        s_d.rdata = '0;
        s_d.req   = dev_irq_i;
        ipi_set   = '0;
        ipi_clr   = '0;
        tmr_clr   = '0;
        mask_we   = '0;
        misc_empty = (req_wdata_i[15:4] == 12'd0) && !req_wdata_i[MISC_ACCEPT];
        if (req_valid_i) begin
            if (bad) begin
                s_d.err = 1'b1;
            end else if (req_write_i) begin
                case (kind)
                    K_MISC: begin
                        if (misc_empty) begin
                            s_d.err = 1'b1;
                        end else begin
                            ipi_set = req_wdata_i[F_IPI_SET +: NCPU];
                            ipi_clr = req_wdata_i[F_IPI_CLR +: NCPU];
                            tmr_clr = req_wdata_i[F_TMR_CLR +: NCPU];
                        end
                    end
                    K_MASK:    mask_we[cpu_sel] = 1'b1;
                    K_IPI_CLR: ipi_clr = req_wdata_i[NCPU-1:0];
                    K_TMR_CLR: tmr_clr = req_wdata_i[NCPU-1:0];
                    K_IPI_SET: ipi_set = req_wdata_i[NCPU-1:0];
                    default:   s_d.err = 1'b1;
                endcase
            end else begin
                case (kind)
                    K_ZERO: s_d.rdata = '0;
                    K_MISC: begin
                        s_d.rdata[F_IPI_CLR +: NCPU] = s_q.ipi;
                        s_d.rdata[F_TMR_CLR +: NCPU] = s_q.tmr;
                        s_d.rdata[1:0] = req_cpu_i;
                    end
                    K_MASK:    s_d.rdata = mask_arr[cpu_sel];
                    K_PEND:    s_d.rdata = pend_arr[cpu_sel];
                    K_REQ:     s_d.rdata = s_q.req;
                    K_IPI_CLR: s_d.rdata[NCPU-1:0] = s_q.ipi;
                    K_TMR_CLR: s_d.rdata[NCPU-1:0] = s_q.tmr;
                    default:   s_d.err = 1'b1;
                endcase
            end
        end
        s_d.ipi = (s_q.ipi & ~ipi_clr) | ipi_set;
        s_d.tmr = tick_i ? '1 : (s_q.tmr & ~tmr_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar n = 0; n < NCPU; n++) begin : g_cpu
        dic_cpu_slice #(.DATA_W(DATA_W)) i_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .mask_we_i   (mask_we[n]),
            .mask_wdata_i(req_wdata_i),
            .req_d_i     (s_d.req),
            .mask_o      (mask_arr[n]),
            .pend_o      (pend_arr[n]),
            .dev_int_o   (dev_int_o[n])
        );

        // R3: pending of this slice tracks its mask and the shared request register
        p_pend_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
            pend_arr[n] == (mask_arr[n] & s_q.req));
    end

    assign ack_o     = s_q.ack;
    assign err_o     = s_q.err;
    assign rdata_o   = s_q.rdata;
    assign tmr_int_o = s_q.tmr;

    p_ack_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> ack_o);
    p_ack_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!ack_o && !err_o));
    p_bad_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_size_i != SZ_64 && !tick_i) |=>
        (err_o && $stable(tmr_int_o) && $stable(mask_arr) && $stable(s_q.ipi)));
    p_tick_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (&tmr_int_o));
    p_misc_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && kind == K_MISC && misc_empty) |=> err_o);
endmodule

// File: tb/test_dev_irq_ctrl.sv
module test_dev_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] dev_irq = '0;
    logic        tick = 1'b0;
    logic        valid = 1'b0;
    logic        write = 1'b0;
    logic [11:0] addr = '0;
    logic [1:0]  size = 2'd3;
    logic [63:0] wdata = '0;
    logic [1:0]  cpu = '0;
    logic        ack, err;
    logic [63:0] rdata;
    logic [3:0]  dev_int, tmr_int;

    int n_checks = 0;
    int n_errors = 0;

    logic [63:0] m_mask [4];
    logic [63:0] m_req;
    logic [3:0]  m_ipi, m_tmr;

    dev_irq_ctrl i_dev_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .dev_irq_i(dev_irq), .tick_i(tick),
        .req_valid_i(valid), .req_write_i(write), .req_addr_i(addr),
        .req_size_i(size), .req_wdata_i(wdata), .req_cpu_i(cpu),
        .ack_o(ack), .err_o(err), .rdata_o(rdata),
        .dev_int_o(dev_int), .tmr_int_o(tmr_int)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit m_err(bit wr, int idx, logic [1:0] sz, logic [63:0] wd, logic [5:0] lo);
        if (sz != 2'd3 || lo[2:0] != 3'd0 || idx > 17) return 1'b1;
        if (wr) begin
            if (idx == 0 || (idx >= 2 && idx <= 5) || (idx >= 10 && idx <= 14)) return 1'b1;
            if (idx == 1 && wd[15:4] == 12'd0 && !wd[28]) return 1'b1;
            return 1'b0;
        end
        return (idx == 17);
    endfunction

    function automatic logic [63:0] m_rd(int idx, logic [1:0] c);
        if (idx == 1) return {52'd0, m_ipi, m_tmr, 2'd0, c};
        if (idx >= 6 && idx <= 9) return m_mask[idx-6];
        if (idx >= 10 && idx <= 13) return m_mask[idx-10] & m_req;
        if (idx == 14) return m_req;
        if (idx == 15) return {60'd0, m_ipi};
        if (idx == 16) return {60'd0, m_tmr};
        return 64'd0;
    endfunction

    function automatic logic [3:0] m_dev();
        logic [3:0] r;
        for (int n = 0; n < 4; n++) r[n] = |(m_mask[n] & m_req);
        return r;
    endfunction

    task automatic chk_outs(input string tag);
        chk({tag, " R4 dev_int"}, {60'd0, dev_int}, {60'd0, m_dev()});
        chk({tag, " R8 tmr_int"}, {60'd0, tmr_int}, {60'd0, m_tmr});
    endtask

    task automatic acc(input string tag, input bit wr, input int idx, input logic [1:0] sz,
                       input logic [63:0] wd, input logic [1:0] c, input logic [5:0] lo,
                       input bit tk);
        bit          e_err;
        logic [63:0] e_rd;
        e_err = m_err(wr, idx, sz, wd, lo);
        e_rd  = m_rd(idx, c);
        @(negedge clk);
        valid = 1'b1; write = wr; addr = 12'(idx * 64) | {6'd0, lo};
        size = sz; wdata = wd; cpu = c; tick = tk;
        @(negedge clk);
        valid = 1'b0; tick = 1'b0;
        chk({tag, " R12 ack"}, {63'd0, ack}, 64'd1);
        chk({tag, " err"}, {63'd0, err}, {63'd0, e_err});
        if (!wr && !e_err) chk({tag, " R11 rdata"}, rdata, e_rd);
        if (wr && !e_err) begin
            if (idx == 1) begin
                m_ipi = (m_ipi & ~wd[11:8]) | wd[15:12];
                m_tmr = m_tmr & ~wd[7:4];
            end else if (idx >= 6 && idx <= 9) m_mask[idx-6] = wd;
            else if (idx == 15) m_ipi = m_ipi & ~wd[3:0];
            else if (idx == 16) m_tmr = m_tmr & ~wd[3:0];
            else if (idx == 17) m_ipi = m_ipi | wd[3:0];
        end
        if (tk) m_tmr = 4'hF;
        chk_outs(tag);
    endtask

    task automatic set_lines(input logic [63:0] v);
        @(negedge clk);
        dev_irq = v;
        @(negedge clk);
        m_req = v;
        chk_outs("R5 lines");
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        m_tmr = 4'hF;
        chk_outs("R8 tick");
    endtask

    initial begin
        #(20 * 150000);
        n_errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int n = 0; n < 4; n++) m_mask[n] = '0;
        m_req = '0; m_ipi = '0; m_tmr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset ack", {63'd0, ack}, 64'd0);
        chk_outs("reset");
        acc("R11 reset mask", 0, 6, 2'd3, 0, 0, 0, 0);

        // R10 zero registers and misc layout
        acc("R10 ctrl", 0, 0, 2'd3, 0, 2, 0, 0);
        acc("R10 aar", 0, 4, 2'd3, 0, 1, 0, 0);
        acc("R9 ipi set", 1, 17, 2'd3, 64'h5, 0, 0, 0);
        do_tick();
        acc("R10 misc read", 0, 1, 2'd3, 0, 3, 0, 0);

        // R3 R4 masking
        set_lines(64'h0000_0000_0000_0100);
        acc("R3 mask0", 1, 6, 2'd3, 64'h0000_0000_0000_0100, 0, 0, 0);
        acc("R3 pend0", 0, 10, 2'd3, 0, 0, 0, 0);
        acc("R4 unmask last", 1, 6, 2'd3, 64'h0000_0000_0000_0200, 0, 0, 0);
        acc("R1 offset bits ignored", 0, 6, 2'd3, 0, 0, 6'h38, 0);

        // R5 repeated clear of an already-clear line
        set_lines(64'h0);
        set_lines(64'h0);
        acc("R5 req", 0, 14, 2'd3, 0, 0, 0, 0);

        // R2 bad size and misalignment
        acc("R2 byte write", 1, 7, 2'd0, 64'hFFFF, 0, 0, 0);
        acc("R2 word write", 1, 17, 2'd2, 64'hF, 0, 0, 0);
        acc("R2 misaligned", 1, 7, 2'd3, 64'hFFFF, 0, 6'h04, 0);
        acc("R2 mask unchanged", 0, 7, 2'd3, 0, 0, 0, 0);

        // R6 R7 misc
        acc("R6 set and clear", 1, 1, 2'd3, 64'h0000_3300, 0, 0, 0);
        acc("R6 tmr clear", 1, 1, 2'd3, 64'h0000_0050, 0, 0, 0);
        acc("R7 accept bit only", 1, 1, 2'd3, 64'h1000_0000, 0, 0, 0);
        acc("R7 empty misc", 1, 1, 2'd3, 64'h0000_0000, 0, 0, 0);
        acc("R10 misc after", 0, 1, 2'd3, 0, 1, 0, 0);

        // R8 R9 timer
        acc("R9 tmr clr", 1, 16, 2'd3, 64'h3, 0, 0, 0);
        acc("R8 tick beats clear", 1, 16, 2'd3, 64'hF, 0, 0, 1);
        do_tick();
        acc("R9 ipi clr", 1, 15, 2'd3, 64'hF, 0, 0, 0);

        // R12 error cases
        acc("R12 unimpl", 0, 30, 2'd3, 0, 0, 0, 0);
        acc("R12 write pend", 1, 11, 2'd3, 64'h1, 0, 0, 0);
        acc("R12 read ipi set", 0, 17, 2'd3, 0, 0, 0, 0);

        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0: set_lines({$urandom, $urandom});
                1: acc("R3 rnd mask", 1, 6 + int'($urandom % 4), 2'd3,
                       ($urandom % 4 == 0) ? 64'd0 : {$urandom, $urandom}, 0, 0, 0);
                2: acc("R11 rnd read", 0, 1 + int'($urandom % 16), 2'd3, 0,
                       2'($urandom), 6'($urandom) & 6'h38, 0);
                3: acc("R6 rnd misc", 1, 1, 2'd3,
                       {32'd0, 3'd0, 1'($urandom), 12'd0, 16'($urandom) & 16'hFFF0}, 0, 0,
                       ($urandom % 8 == 0));
                4: do_tick();
                default: acc("R2 rnd any", 1'($urandom), int'($urandom % 20), 2'($urandom),
                             {$urandom, $urandom}, 2'($urandom), 6'($urandom), 0);
            endcase
        end

        @(negedge clk);
        chk("R12 idle ack", {63'd0, ack}, 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule